// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block drives the column side of one bank of a 32-bit synchronous DRAM interface. Each clock it takes a command (idle, read, write or terminate) with a starting column. A read or write starts a burst, and the block then puts out one column address per clock. The number of columns and their wrap order come from a mode setting: burst length, ordering, and read latency. Write beats carry four per-lane byte masks. Read beats come back as a data-valid strobe, delayed by the programmed latency.

A new read or write can replace a burst on any cycle. The sequence then restarts from the new column. A terminate command stops the burst at once. Read beats already issued still reach the data-valid output. An illegal mode setting is flagged, and reads and writes are refused while it lasts. An optional single-write mode limits every write to one beat, while reads keep the programmed length.

Top module: `sdram_burst_seq`

## Requirements
- R1: While rst_n is low at a rising edge, every output is 0 after that edge.
- R2: Legal settings are as follows. len_sel is 000=1, 001=2, 010=4, 011=8 or 111=full page. The interleave bit is allowed only with the codes 000 to 011. rd_lat is 2 or 3. With any other setting, cfg_err is 1 after the next edge, and read or write commands on that edge are ignored. An ongoing burst continues.
- R3: In sequential order, beat n of a burst of length L keeps the column bits above log2(L) from the start column. Its low log2(L) bits are (start + n) mod L. A full-page burst puts out (start + n) mod 256 and runs until it is terminated or replaced.
- R4: In interleaved order, beat n keeps the upper bits and sets the low log2(L) bits to start XOR n.
- R5: A read or write sampled at edge k puts beat n on col_addr with col_vld=1 after edge k+n. col_is_wr is 1 for write beats and 0 for read beats. col_vld is 0 when no beat is issued.
- R6: A terminate (cmd=11) sampled at an edge makes col_vld 0 after that edge. No further beats follow until a new command.
- R7: A read (cmd=01) or write (cmd=10) sampled during a burst abandons that burst. Its start column appears after the same edge, with the new direction.
- R8: For a read beat shown after edge j, rd_data_vld is 1 after edge j+rd_lat and is 0 otherwise. Beats already issued still emerge after a terminate or an interruption.
- R9: On a write beat, wr_lane_mask equals lane_mask (bit i = byte lane i, 1 = suppressed) sampled on the edge that issued the beat. Otherwise it is 0.
- R10: With single_wr=1, a write issues exactly one beat, whatever the length. Reads use the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| len_sel | input | 3 | Burst length code |
| ilv_order | input | 1 | 1 = interleaved order, 0 = sequential |
| rd_lat | input | 2 | Read latency in clocks (2 or 3) |
| single_wr | input | 1 | 1 = writes are single-beat |
| cmd | input | 2 | 00 idle, 01 read, 10 write, 11 terminate |
| cmd_col | input | 8 | Start column for read or write |
| lane_mask | input | 4 | Byte-lane masks for the current write beat |
| col_addr | output | 8 | Column of the current beat |
| col_vld | output | 1 | A beat is issued this cycle |
| col_is_wr | output | 1 | The current beat is a write |
| wr_lane_mask | output | 4 | Lane masks of the current write beat |
| rd_data_vld | output | 1 | Read data expected this cycle |
| cfg_err | output | 1 | Mode setting was illegal at the last edge |

## Verification
The bound checker watches several rules on every cycle. It checks that a terminate silences the column output and that a legal command shows its start column one edge later. It checks that lane masks appear only on write beats and follow the input, and that read-valid trails read beats by exactly the latency. It also checks that single writes stop after one beat and that a full-page sequential burst steps by one. The exact wrap order of every fixed length in both orderings is shown only by the bench's reference model. So are the refusal of each illegal setting and long random mixes of interruptions and terminates.

// File: rtl/sbs_pkg.sv
// Package: shared command encoding and length codes for the burst column
// sequencer. Assumes 2-bit commands and 3-bit length codes.
package sbs_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_WR   = 2'b10,
        CMD_TERM = 2'b11
    } cmd_e;

    localparam logic [2:0] LEN_FULL = 3'b111;
    localparam logic [2:0] LEN_MAXFIX = 3'b011;
endpackage

// File: rtl/sbs_cfg_chk.sv
// Module: mode legality check. Decides whether the combination of length
// code, ordering and read latency may start a burst. Purely combinational;
// assumes LAT_MIN..LAT_MAX is the legal latency range.
module sbs_cfg_chk #(
    parameter int LEN_W   = 3,
    parameter int LAT_W   = 2,
    parameter int LAT_MIN = 2,
    parameter int LAT_MAX = 3
) (
    input  logic [LEN_W-1:0] len_sel,
    input  logic             ilv_order,
    input  logic [LAT_W-1:0] rd_lat,
    output logic             cfg_ok
);
    import sbs_pkg::*;

    logic len_fixed;
    logic len_full;
    logic lat_ok;

    // Classify the length code and latency, then combine.
    always_comb begin
        len_fixed = (len_sel <= LEN_MAXFIX);
        len_full  = (len_sel == LEN_FULL);
        lat_ok    = (int'(rd_lat) >= LAT_MIN) && (int'(rd_lat) <= LAT_MAX);
        cfg_ok    = lat_ok && (len_fixed || (len_full && !ilv_order));
    end
endmodule

// File: rtl/sbs_col_gen.sv
// Module: column generator. From the burst's start column, beat index and
// latched length code it forms the column of that beat in sequential or
// interleaved order. Also returns the low-bit wrap mask, which equals the
// index of the last beat for fixed lengths. Assumes length codes 0..3
// mean 2**code beats and the full-page code wraps the whole column field.
module sbs_col_gen #(
    parameter int COL_W = 8,
    parameter int LEN_W = 3
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [LEN_W-1:0] len_code,
    input  logic             ilv_order,
    output logic [COL_W-1:0] beat_col,
    output logic [COL_W-1:0] wrap_mask
);
    import sbs_pkg::*;

    logic             is_full;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    // Build the wrap mask: one bit per low column bit that wraps.
    always_comb begin
        is_full = (len_code == LEN_FULL);
        for (int i = 0; i < COL_W; i++) begin
            wrap_mask[i] = is_full || (i < int'(len_code));
        end
    end

    // Form the beat column: upper bits held, low bits advanced or XORed.
    always_comb begin
        seq_low  = start_col + beat_idx;
        ilv_low  = start_col ^ beat_idx;
        beat_col = (start_col & ~wrap_mask)
                 | ((ilv_order ? ilv_low : seq_low) & wrap_mask);
    end
endmodule

// File: rtl/sbs_rd_pipe.sv
// Module: read-valid delay line. Shifts a read-beat flag through LAT_MAX
// stages and taps the stage selected by the latency, so that the flag
// leaves rd_lat clocks after the beat. Assumes LAT_MAX >= 2; a latency
// below 2 taps the second stage.
module sbs_rd_pipe #(
    parameter int LAT_MAX = 3,
    parameter int LAT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_in,
    input  logic [LAT_W-1:0] rd_lat,
    output logic             vld_out
);
    logic [LAT_MAX-1:0] stage_q;

    // Shift the read-beat flag one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[LAT_MAX-2:0], beat_in};
        end
    end

    // Pick the tap that matches the programmed latency.
    always_comb begin
        vld_out = stage_q[1];
        for (int i = 1; i < LAT_MAX; i++) begin
            if (int'(rd_lat) == i + 1) begin
                vld_out = stage_q[i];
            end
        end
    end
endmodule

// File: rtl/sbs_burst_ctl.sv
// Module: burst controller. Accepts read/write/terminate commands, latches
// the burst shape at issue, counts beats and registers the column, valid,
// direction and lane-mask outputs. A new command replaces a burst on any
// edge. Assumes the mode inputs change only while no burst is running.
module sbs_burst_ctl #(
    parameter int COL_W = 8,
    parameter int LEN_W = 3,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [LANES-1:0] lane_mask,
    input  logic [LEN_W-1:0] len_sel,
    input  logic             ilv_order,
    input  logic             single_wr,
    input  logic             cfg_ok,
    output logic [COL_W-1:0] col_addr,
    output logic             col_vld,
    output logic             col_is_wr,
    output logic [LANES-1:0] wr_lane_mask
);
    import sbs_pkg::*;

    cmd_e             cmd_c;
    logic             issue;
    logic             is_wr_cmd;
    logic             active_q;
    logic             wr_q;
    logic             ilv_q;
    logic [LEN_W-1:0] len_q;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] next_col;
    logic [COL_W-1:0] wrap_mask;
    logic             full_q;

    // Decode the command and decide whether it starts a burst.
    always_comb begin
        cmd_c     = cmd_e'(cmd);
        is_wr_cmd = (cmd_c == CMD_WR);
        issue     = cfg_ok && ((cmd_c == CMD_RD) || (cmd_c == CMD_WR));
        full_q    = (len_q == LEN_FULL);
    end

    sbs_col_gen #(
        .COL_W(COL_W),
        .LEN_W(LEN_W)
    ) u_col_gen (
        .start_col(start_q),
        .beat_idx (cnt_q),
        .len_code (len_q),
        .ilv_order(ilv_q),
        .beat_col (next_col),
        .wrap_mask(wrap_mask)
    );

    // Burst state: latch shape at issue, advance the beat count while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            ilv_q    <= 1'b0;
            len_q    <= '0;
            start_q  <= '0;
            cnt_q    <= '0;
        end else if (cmd_c == CMD_TERM) begin
            active_q <= 1'b0;
        end else if (issue) begin
            start_q  <= cmd_col;
            len_q    <= len_sel;
            ilv_q    <= ilv_order;
            wr_q     <= is_wr_cmd;
            cnt_q    <= {{(COL_W-1){1'b0}}, 1'b1};
            active_q <= (len_sel != '0) && !(is_wr_cmd && single_wr);
        end else if (active_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (!full_q && (cnt_q == wrap_mask)) begin
                active_q <= 1'b0;
            end
        end
    end

    // Output register: column, valid, direction and write lane masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_addr     <= '0;
            col_vld      <= 1'b0;
            col_is_wr    <= 1'b0;
            wr_lane_mask <= '0;
        end else if (cmd_c == CMD_TERM) begin
            col_vld      <= 1'b0;
            col_is_wr    <= 1'b0;
            wr_lane_mask <= '0;
        end else if (issue) begin
            col_addr     <= cmd_col;
            col_vld      <= 1'b1;
            col_is_wr    <= is_wr_cmd;
            wr_lane_mask <= is_wr_cmd ? lane_mask : '0;
        end else if (active_q) begin
            col_addr     <= next_col;
            col_vld      <= 1'b1;
            col_is_wr    <= wr_q;
            wr_lane_mask <= wr_q ? lane_mask : '0;
        end else begin
            col_vld      <= 1'b0;
            col_is_wr    <= 1'b0;
            wr_lane_mask <= '0;
        end
    end
endmodule

// File: rtl/sdram_burst_seq.sv
// Module: top of the burst column sequencer. Ties together the mode
// check, the burst controller and the read-valid delay line, and
// registers the illegal-mode flag. Assumes mode inputs are held steady
// while bursts or read-valid beats are in flight.
module sdram_burst_seq #(
    parameter int COL_W   = 8,
    parameter int LANES   = 4,
    parameter int LEN_W   = 3,
    parameter int LAT_W   = 2,
    parameter int LAT_MIN = 2,
    parameter int LAT_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_sel,
    input  logic             ilv_order,
    input  logic [LAT_W-1:0] rd_lat,
    input  logic             single_wr,
    input  logic [1:0]       cmd,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [LANES-1:0] lane_mask,
    output logic [COL_W-1:0] col_addr,
    output logic             col_vld,
    output logic             col_is_wr,
    output logic [LANES-1:0] wr_lane_mask,
    output logic             rd_data_vld,
    output logic             cfg_err
);
    logic cfg_ok;
    logic rd_beat;

    sbs_cfg_chk #(
        .LEN_W  (LEN_W),
        .LAT_W  (LAT_W),
        .LAT_MIN(LAT_MIN),
        .LAT_MAX(LAT_MAX)
    ) u_cfg_chk (
        .len_sel  (len_sel),
        .ilv_order(ilv_order),
        .rd_lat   (rd_lat),
        .cfg_ok   (cfg_ok)
    );

    sbs_burst_ctl #(
        .COL_W(COL_W),
        .LEN_W(LEN_W),
        .LANES(LANES)
    ) u_burst_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .cmd_col     (cmd_col),
        .lane_mask   (lane_mask),
        .len_sel     (len_sel),
        .ilv_order   (ilv_order),
        .single_wr   (single_wr),
        .cfg_ok      (cfg_ok),
        .col_addr    (col_addr),
        .col_vld     (col_vld),
        .col_is_wr   (col_is_wr),
        .wr_lane_mask(wr_lane_mask)
    );

    // A read beat is any issued beat that is not a write.
    always_comb begin
        rd_beat = col_vld && !col_is_wr;
    end

    sbs_rd_pipe #(
        .LAT_MAX(LAT_MAX),
        .LAT_W  (LAT_W)
    ) u_rd_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_in(rd_beat),
        .rd_lat (rd_lat),
        .vld_out(rd_data_vld)
    );

    // Register the illegal-mode flag each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !cfg_ok;
        end
    end
endmodule

// File: rtl/sbs_checker.sv
// Module: property checker for the burst column sequencer, bound to the
// top. Assumes mode inputs are stable while bursts run, as the top does.
module sbs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] len_sel,
    input logic       ilv_order,
    input logic [1:0] rd_lat,
    input logic       single_wr,
    input logic [1:0] cmd,
    input logic [7:0] cmd_col,
    input logic [3:0] lane_mask,
    input logic [7:0] col_addr,
    input logic       col_vld,
    input logic       col_is_wr,
    input logic [3:0] wr_lane_mask,
    input logic       rd_data_vld
);
    logic mode_legal;
    logic rd_out;

    // Independent legality view and read-beat flag used by the properties.
    always_comb begin
        mode_legal = ((len_sel <= 3'd3) || (len_sel == 3'd7 && !ilv_order))
                   && ((rd_lat == 2'd2) || (rd_lat == 2'd3));
        rd_out     = col_vld && !col_is_wr;
    end

    AST_TERM_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b11 |=> !col_vld); // R6

    AST_START_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_legal && (cmd == 2'b01 || cmd == 2'b10))
        |=> col_vld && col_addr == $past(cmd_col)
            && col_is_wr == ($past(cmd) == 2'b10)); // R7

    AST_MASK_ON_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lane_mask != 4'b0) |-> (col_vld && col_is_wr)); // R9

    AST_MASK_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld && col_is_wr) |-> wr_lane_mask == $past(lane_mask)); // R9

    AST_RD_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lat == 2'd2 && $past(rd_lat) == 2'd2 && $past(rd_lat, 2) == 2'd2)
        |-> rd_data_vld == $past(rd_out, 2)); // R8

    AST_RD_LAT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lat == 2'd3 && $past(rd_lat) == 2'd3 && $past(rd_lat, 2) == 2'd3
         && $past(rd_lat, 3) == 2'd3)
        |-> rd_data_vld == $past(rd_out, 3)); // R8

    AST_SINGLE_WRITE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (single_wr && $past(single_wr) && col_vld && col_is_wr && cmd == 2'b00)
        |=> !col_vld); // R10

    AST_FULL_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (len_sel == 3'd7 && !ilv_order && col_vld && cmd == 2'b00
         && !(col_is_wr && single_wr))
        |=> col_vld && col_addr == $past(col_addr) + 8'd1); // R3
endmodule

bind sdram_burst_seq sbs_checker u_sbs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .len_sel     (len_sel),
    .ilv_order   (ilv_order),
    .rd_lat      (rd_lat),
    .single_wr   (single_wr),
    .cmd         (cmd),
    .cmd_col     (cmd_col),
    .lane_mask   (lane_mask),
    .col_addr    (col_addr),
    .col_vld     (col_vld),
    .col_is_wr   (col_is_wr),
    .wr_lane_mask(wr_lane_mask),
    .rd_data_vld (rd_data_vld)
);

// File: tb/sim_sdram_burst_seq.sv
// Bench: directed corners plus seeded random command streams, compared
// each cycle against a reference model built from the requirements.
module sim_sdram_burst_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] len_sel = 3'd0;
    logic       ilv_order = 1'b0;
    logic [1:0] rd_lat = 2'd2;
    logic       single_wr = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [7:0] cmd_col = 8'd0;
    logic [3:0] lane_mask = 4'd0;
    logic [7:0] col_addr;
    logic       col_vld;
    logic       col_is_wr;
    logic [3:0] wr_lane_mask;
    logic       rd_data_vld;
    logic       cfg_err;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .ilv_order(ilv_order),
        .rd_lat(rd_lat), .single_wr(single_wr), .cmd(cmd), .cmd_col(cmd_col),
        .lane_mask(lane_mask), .col_addr(col_addr), .col_vld(col_vld),
        .col_is_wr(col_is_wr), .wr_lane_mask(wr_lane_mask),
        .rd_data_vld(rd_data_vld), .cfg_err(cfg_err)
    );

    // Reference: column of beat n from the R3/R4 rules.
    function automatic int ref_col(int start, int n, int code, bit ilv);
        int l, lo, hi;
        if (code == 7) return (start + n) % 256;
        l  = 1 << code;
        lo = start % l;
        hi = start - lo;
        if (ilv) return hi + (lo ^ (n % l));
        return hi + ((lo + n) % l);
    endfunction

    function automatic bit legal_mode(int code, bit ilv, int lat);
        return ((code <= 3) || (code == 7 && !ilv)) && (lat == 2 || lat == 3);
    endfunction

    // Model state and expected outputs.
    bit    m_act, m_wr, m_ilv;
    int    m_start, m_code, m_n, m_beats;
    bit    e_vld, e_wr, e_rd, e_err;
    int    e_col;
    logic [3:0] e_mask;
    bit [2:0]   m_pipe;
    string m_tag = "R1";

    // Reference model: advances once per rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_wr = 0; m_ilv = 0; m_n = 0; m_beats = 0;
            e_vld = 0; e_wr = 0; e_rd = 0; e_err = 0; e_col = 0;
            e_mask = 4'd0; m_pipe = 3'd0; m_tag = "R1";
        end else begin
            bit ok;
            ok = legal_mode(int'(len_sel), ilv_order, int'(rd_lat));
            e_err  = !ok;
            m_pipe = {m_pipe[1:0], e_vld && !e_wr};
            e_rd   = (rd_lat == 2'd3) ? m_pipe[2] : m_pipe[1];
            if (cmd == 2'b11) begin
                m_act = 0; e_vld = 0; e_wr = 0; e_mask = 4'd0; m_tag = "R6";
            end else if ((cmd == 2'b01 || cmd == 2'b10) && ok) begin
                m_tag   = m_act ? "R7" : "R5";
                m_start = int'(cmd_col);
                m_code  = int'(len_sel);
                m_ilv   = ilv_order;
                m_wr    = (cmd == 2'b10);
                m_beats = (m_wr && single_wr) ? 1 :
                          (m_code == 7) ? 0 : (1 << m_code);
                e_col = m_start; e_vld = 1; e_wr = m_wr;
                e_mask = m_wr ? lane_mask : 4'd0;
                m_n = 1;
                m_act = (m_beats != 1);
            end else if (m_act) begin
                m_tag = (cmd != 2'b00) ? "R2" : "R5";
                e_col = ref_col(m_start, m_n, m_code, m_ilv);
                e_vld = 1; e_wr = m_wr;
                e_mask = m_wr ? lane_mask : 4'd0;
                m_n++;
                if (m_beats != 0 && m_n == m_beats) m_act = 0;
            end else begin
                if (cmd != 2'b00) m_tag = "R2";
                else if (e_vld && e_wr && single_wr) m_tag = "R10";
                else m_tag = "R5";
                e_vld = 0; e_wr = 0; e_mask = 4'd0;
            end
        end
    end

    task automatic check(input int act, input int exp, input string tag, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model; called away from the edge.
    task automatic compare();
        check(int'(col_vld), int'(e_vld), m_tag, "col_vld");
        if (e_vld) begin
            check(int'(col_is_wr), int'(e_wr), "R5", "col_is_wr");
            check(int'(col_addr), e_col, m_ilv ? "R4" : "R3", "col_addr");
        end
        check(int'(wr_lane_mask), int'(e_mask), (!rst_n) ? "R1" : "R9", "wr_lane_mask");
        check(int'(rd_data_vld), int'(e_rd), (!rst_n) ? "R1" : "R8", "rd_data_vld");
        check(int'(cfg_err), int'(e_err), (!rst_n) ? "R1" : "R2", "cfg_err");
    endtask

    task automatic step(input logic [1:0] c, input logic [7:0] a, input logic [3:0] m);
        @(negedge clk);
        compare();
        cmd = c; cmd_col = a; lane_mask = m;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2'b00, 8'd0, 4'($urandom));
    endtask

    task automatic set_mode(input int code, input bit ilv, input int lat, input bit sw);
        step(2'b11, 8'd0, 4'd0);
        idle(5);
        @(negedge clk);
        compare();
        len_sel = 3'(code); ilv_order = ilv; rd_lat = 2'(lat); single_wr = sw;
        cmd = 2'b00;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int codes[5] = '{0, 1, 2, 3, 7};
        void'($urandom(32'd5150));
        // R1: reset state.
        for (int i = 0; i < 4; i++) step(2'b01, 8'd9, 4'hF);
        @(negedge clk);
        compare();
        cmd = 2'b00;
        rst_n = 1'b1;
        idle(3);

        // Every legal length and ordering, reads and writes (R3, R4, R5, R8, R9).
        for (int ci = 0; ci < 5; ci++) begin
            for (int il = 0; il < 2; il++) begin
                if (codes[ci] == 7 && il == 1) continue;
                set_mode(codes[ci], bit'(il), 2 + (ci % 2), 1'b0);
                step(2'b01, 8'($urandom), 4'd0);
                idle(codes[ci] == 7 ? 300 : 12);
                step(2'b10, 8'($urandom), 4'($urandom));
                idle(codes[ci] == 7 ? 20 : 12);
            end
        end

        // Illegal combinations are refused (R2).
        set_mode(4, 1'b0, 2, 1'b0); step(2'b01, 8'd3, 4'd0); idle(4);
        set_mode(5, 1'b0, 3, 1'b0); step(2'b10, 8'd3, 4'd1); idle(4);
        set_mode(6, 1'b0, 2, 1'b0); step(2'b01, 8'd3, 4'd0); idle(4);
        set_mode(7, 1'b1, 2, 1'b0); step(2'b01, 8'd3, 4'd0); idle(4);
        set_mode(3, 1'b0, 1, 1'b0); step(2'b01, 8'd3, 4'd0); idle(4);
        set_mode(3, 1'b0, 0, 1'b0); step(2'b10, 8'd3, 4'd2); idle(4);

        // Terminate mid-burst with reads in flight (R6, R8).
        set_mode(3, 1'b0, 3, 1'b0);
        step(2'b01, 8'd13, 4'd0); idle(3); step(2'b11, 8'd0, 4'd0); idle(6);
        // Interrupt on consecutive cycles and mid-burst (R7).
        set_mode(3, 1'b1, 2, 1'b0);
        step(2'b01, 8'd250, 4'd0); step(2'b01, 8'd7, 4'd0); idle(2);
        step(2'b10, 8'd100, 4'hA); idle(1); step(2'b01, 8'd33, 4'd0); idle(10);
        // Single-write mode: writes one beat, reads full length (R10).
        set_mode(2, 1'b0, 2, 1'b1);
        step(2'b10, 8'd22, 4'h5); idle(4);
        step(2'b01, 8'd22, 4'd0); idle(8);
        set_mode(7, 1'b0, 3, 1'b1);
        step(2'b10, 8'd255, 4'h3); idle(4);

        // Random command streams under each legal mode.
        for (int blk = 0; blk < 24; blk++) begin
            int ci = int'($urandom % 5);
            bit il = (codes[ci] != 7) && ($urandom % 2 == 1);
            set_mode(codes[ci], il, 2 + int'($urandom % 2), bit'($urandom % 2));
            for (int i = 0; i < 150; i++) begin
                int r = int'($urandom % 100);
                logic [1:0] c;
                c = (r < 70) ? 2'b00 : (r < 82) ? 2'b01 : (r < 94) ? 2'b10 : 2'b11;
                step(c, 8'($urandom), 4'($urandom));
            end
        end

        idle(5);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule